// File: doc/BRIEF.md
# Interrupt Pin Merge Controller

This block gathers three event strobes into one external interrupt pin: watchdog expiry, alarm match and power-fail detect. Every strobe sets its own sticky flag, whether or not it is enabled. A strobe whose enable bit is set also drives the pin. The detection logic for each event lives outside the block. The events arrive here as single-cycle strobes.

An 8-bit control register sets up the pin. It holds one enable per source, a polarity/drive bit and a mode bit. In level mode the pin stays active until software reads the flags. In pulse mode the pin stays active for a fixed number of periods of a slow tick, about 219 ms with a 32 Hz tick. When active-high drive is chosen, the pin is driven push-pull. Otherwise it is modelled as an open-drain line, with an output enable that pulls the pin low only while it is active. Reading the flags returns all three flags and clears them.

Top module: `irq_out_ctrl`

## Requirements
- R1: The control byte keeps bit 7 (watchdog enable), bit 6 (alarm enable), bit 5 (power-fail enable), bit 2 (1 = active-high push-pull, 0 = open-drain active-low) and bit 1 (1 = pulse mode, 0 = level mode). Bits 4, 3 and 0 always read as 0. The register changes only when it is written.
- R2: A strobe sets its flag whether or not it is enabled. The flag shows on flag_rdata_o one cycle after the strobe: bit 2 for watchdog, bit 1 for alarm, bit 0 for power-fail. The flag holds until it is read.
- R3: A flag read returns the current flags during the read cycle and clears them at the clock edge that ends the read. A strobe in the read cycle leaves its flag set.
- R4: A strobe makes the pin active one cycle later only if its enable bit is 1. Strobes from disabled sources leave the pin untouched.
- R5: In level mode, an active pin stays active for any number of cycles until a flag read. The read releases the pin at the edge that ends the read.
- R6: In level mode, an enabled strobe in the same cycle as a flag read keeps the pin active.
- R7: In pulse mode, the pin stays active until PULSE_TICKS tick periods have passed after the strobe. It then releases with no read. A flag read does not release it.
- R8: In pulse mode, an enabled strobe during an active pulse restarts the full PULSE_TICKS count.
- R9: With bit 2 = 1, irq_o follows the active state and irq_oe_o is 1. With bit 2 = 0, irq_o is 0 and irq_oe_o is 1 only while the pin is active.
- R10: Reset clears the control byte and the flags, and leaves irq_o = 0 and irq_oe_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe of the slow pulse time base |
| wd_evt_i | input | 1 | Watchdog expiry strobe |
| alm_evt_i | input | 1 | Alarm match strobe |
| pf_evt_i | input | 1 | Power-fail detect strobe |
| ctrl_we_i | input | 1 | Control byte write enable |
| ctrl_wdata_i | input | 8 | Control byte write data |
| ctrl_rdata_o | output | 8 | Control byte read value |
| flag_rd_i | input | 1 | Flag read strobe; clears the flags |
| flag_rdata_o | output | 3 | Flags {watchdog, alarm, power-fail} |
| irq_o | output | 1 | Pin value (push-pull high when active; 0 in open-drain mode) |
| irq_oe_o | output | 1 | Pin output enable |

## Verification
A vector table tries enable masks, polarity and mode settings against single and combined strobes. Each row tells apart flag-only events from pin-driving events, and push-pull drive from open-drain drive. Directed cases cover the rest:
- holding the pin over idle cycles, to separate level mode from pulse mode;
- a read that coincides with a strobe;
- counting ticks to the exact release edge of a pulse;
- restarting a pulse partway through its count, to show that it reloads.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;
  localparam int NumSrc    = 3;
  localparam int CtrlW     = 8;
  localparam int BitWdEn   = 7;
  localparam int BitAlmEn  = 6;
  localparam int BitPfEn   = 5;
  localparam int BitPolHi  = 2;
  localparam int BitPulse  = 1;
  localparam logic [CtrlW-1:0] CtrlMask = 8'hE6;

  // src_en order matches strobe vector {wd, alm, pf}
  typedef struct packed {
    logic [NumSrc-1:0] src_en;
    logic              pol_hi;
    logic              pulse;
  } ctrl_t;
endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_out_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CtrlW-1:0] wdata_i,
  output logic [CtrlW-1:0] rdata_o,
  output ctrl_t            ctrl_o
);
  logic [CtrlW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i & CtrlMask;
  end

  assign rdata_o = ctrl_q;

  always_comb begin
    ctrl_o.src_en = {ctrl_q[BitWdEn], ctrl_q[BitAlmEn], ctrl_q[BitPfEn]};
    ctrl_o.pol_hi = ctrl_q[BitPolHi];
    ctrl_o.pulse  = ctrl_q[BitPulse];
  end

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q)); // R1
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               rd_i,
  output logic [NUM_SRC-1:0] flag_o
);
  logic [NUM_SRC-1:0] flag_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (evt_i[i]) flag_q[i] <= 1'b1;  // new event beats the clear
      else if (rd_i)     flag_q[i] <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flag_q[i]); // R2
    AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !evt_i[i]) |=> !flag_q[i]); // R3
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int PULSE_TICKS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic load_i,
  input  logic tick_i,
  output logic active_o
);
  localparam int CntW = $clog2(PULSE_TICKS + 1);
  localparam logic [CntW-1:0] LoadVal = CntW'(PULSE_TICKS);

  logic [CntW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)                       cnt_d = '0;
    else if (load_i)                  cnt_d = LoadVal;
    else if (tick_i && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

  AST_PULSE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && load_i) |=> (cnt_q == LoadVal)); // R8
  AST_PULSE_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> (cnt_q <= $past(cnt_q))); // R7
  AST_PULSE_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !tick_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic pol_hi_i,
  output logic irq_o,
  output logic irq_oe_o
);
  always_comb begin
    if (pol_hi_i) begin
      irq_o    = active_i;
      irq_oe_o = 1'b1;
    end else begin
      irq_o    = 1'b0;      // open drain: only ever pull low
      irq_oe_o = active_i;
    end
  end

  AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pol_hi_i |-> !irq_o); // R9
  AST_HIGH_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_oe_o); // R9
endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl
  import irq_out_pkg::*;
#(
  parameter int PULSE_TICKS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wd_evt_i,
  input  logic              alm_evt_i,
  input  logic              pf_evt_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  output logic [7:0]        ctrl_rdata_o,
  input  logic              flag_rd_i,
  output logic [2:0]        flag_rdata_o,
  output logic              irq_o,
  output logic              irq_oe_o
);
  ctrl_t             ctrl;
  logic [NumSrc-1:0] evt;
  logic              hit;
  logic              lvl_q;
  logic              pulse_active;
  logic              pin_active;

  assign evt = {wd_evt_i, alm_evt_i, pf_evt_i};
  assign hit = |(evt & ctrl.src_en);

  irq_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .rdata_o (ctrl_rdata_o),
    .ctrl_o  (ctrl)
  );

  irq_flag_bank #(.NUM_SRC(NumSrc)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .rd_i   (flag_rd_i),
    .flag_o (flag_rdata_o)
  );

  irq_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl.pulse),
    .load_i   (hit),
    .tick_i   (tick_i),
    .active_o (pulse_active)
  );

  // level hold: set by enabled event, released by flag read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lvl_q <= 1'b0;
    else if (ctrl.pulse) lvl_q <= 1'b0;
    else if (hit)        lvl_q <= 1'b1;
    else if (flag_rd_i)  lvl_q <= 1'b0;
  end

  assign pin_active = ctrl.pulse ? pulse_active : lvl_q;

  irq_pin_drive u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (pin_active),
    .pol_hi_i (ctrl.pol_hi),
    .irq_o    (irq_o),
    .irq_oe_o (irq_oe_o)
  );

  AST_HIT_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !ctrl_we_i) |=> pin_active); // R4
  AST_LVL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.pulse && !ctrl_we_i && flag_rd_i && !hit) |=> !pin_active); // R5
  AST_LVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.pulse && !ctrl_we_i && lvl_q && !flag_rd_i) |=> lvl_q); // R5
  AST_LVL_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.pulse && !ctrl_we_i && hit && flag_rd_i) |=> lvl_q); // R6
endmodule

// File: tb/irq_out_ctrl_tb.sv
module irq_out_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wd = 1'b0, alm = 1'b0, pf = 1'b0;
  logic ctrl_we = 1'b0, flag_rd = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic [2:0] flag_rdata;
  logic irq, irq_oe;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_out_ctrl #(.PULSE_TICKS(7)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wd_evt_i(wd), .alm_evt_i(alm), .pf_evt_i(pf),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .flag_rd_i(flag_rd), .flag_rdata_o(flag_rdata),
    .irq_o(irq), .irq_oe_o(irq_oe)
  );

  // {ctrl, strobes{wd,alm,pf}, exp flags, exp irq, exp oe}
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {8'h84, 3'b100, 3'b100, 1'b1, 1'b1},
    {8'h84, 3'b010, 3'b010, 1'b0, 1'b1},
    {8'h40, 3'b010, 3'b010, 1'b0, 1'b1},
    {8'h40, 3'b001, 3'b001, 1'b0, 1'b0},
    {8'h20, 3'b001, 3'b001, 1'b0, 1'b1},
    {8'h26, 3'b001, 3'b001, 1'b1, 1'b1},
    {8'h00, 3'b111, 3'b111, 1'b0, 1'b0},
    {8'h06, 3'b111, 3'b111, 1'b0, 1'b1},
    {8'hE2, 3'b110, 3'b110, 1'b0, 1'b1},
    {8'hFF, 3'b100, 3'b100, 1'b1, 1'b1}
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {tick, wd, alm, pf, ctrl_we, flag_rd} = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic fire(logic [2:0] e);
    {wd, alm, pf} = e;
    @(negedge clk);
    {wd, alm, pf} = '0;
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] seen;
    // R10 reset state
    do_reset();
    chk("R10 ctrl after reset", ctrl_rdata, 8'h00);
    chk("R10 flags after reset", {5'd0, flag_rdata}, 8'h00);
    chk("R10 irq after reset", {7'd0, irq}, 8'h00);
    chk("R10 oe after reset", {7'd0, irq_oe}, 8'h00);

    // table: R1 R2 R4 R9
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr_ctrl(VEC[v][15:8]);
      chk("R1 ctrl readback", ctrl_rdata, VEC[v][15:8] & 8'hE6);
      fire(VEC[v][7:5]);
      chk("R2 flags", {5'd0, flag_rdata}, {5'd0, VEC[v][4:2]});
      chk("R4 irq", {7'd0, irq}, {7'd0, VEC[v][1]});
      chk("R9 oe", {7'd0, irq_oe}, {7'd0, VEC[v][0]});
    end

    // R3 read returns then clears; same-cycle event survives
    do_reset();
    fire(3'b100);
    repeat (3) @(negedge clk);
    chk("R2 flag holds", {5'd0, flag_rdata}, 8'h04);
    flag_rd = 1'b1; #1 seen = flag_rdata;
    @(negedge clk); flag_rd = 1'b0;
    chk("R3 read value", {5'd0, seen}, 8'h04);
    chk("R3 cleared", {5'd0, flag_rdata}, 8'h00);
    fire(3'b001);
    flag_rd = 1'b1; alm = 1'b1;
    @(negedge clk); flag_rd = 1'b0; alm = 1'b0;
    chk("R3 event in read cycle kept", {5'd0, flag_rdata}, 8'h02);

    // R5 level hold and release; R6 event wins over read
    do_reset();
    wr_ctrl(8'h84);
    fire(3'b100);
    repeat (5) @(negedge clk);
    chk("R5 level held", {7'd0, irq}, 8'h01);
    flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
    chk("R5 released by read", {7'd0, irq}, 8'h00);
    fire(3'b100);
    flag_rd = 1'b1; wd = 1'b1;
    @(negedge clk); flag_rd = 1'b0; wd = 1'b0;
    chk("R6 event beats read", {7'd0, irq}, 8'h01);
    chk("R6 flag kept", {5'd0, flag_rdata}, 8'h04);

    // R7 pulse length, read does not release
    do_reset();
    wr_ctrl(8'h86);
    fire(3'b100);
    flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
    chk("R7 read does not release", {7'd0, irq}, 8'h01);
    tick_n(6);
    chk("R7 active after 6 ticks", {7'd0, irq}, 8'h01);
    tick_n(1);
    chk("R7 released after 7 ticks", {7'd0, irq}, 8'h00);

    // R8 restart during pulse
    fire(3'b100);
    tick_n(4);
    fire(3'b100);
    tick_n(6);
    chk("R8 restarted still active", {7'd0, irq}, 8'h01);
    tick_n(1);
    chk("R8 released after full count", {7'd0, irq}, 8'h00);

    // R9 open drain level
    do_reset();
    wr_ctrl(8'h80);
    chk("R9 od idle oe", {7'd0, irq_oe}, 8'h00);
    fire(3'b100);
    chk("R9 od active oe", {7'd0, irq_oe}, 8'h01);
    chk("R9 od active irq", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule